// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache Controller

This block is a small data cache that sits between one load/store requester and a next-level memory that moves whole 8-byte blocks. It covers an 8-bit byte address space with 4 sets of 2 ways, 64 data bytes in all. Each tag entry carries a valid flag, a 3-bit tag and a dirty flag. Each set also carries one replacement bit that names the way to evict next. A request is accepted while `busy` is low. The controller answers with a single-cycle `resp_valid` pulse that carries the hit flag and, for loads, the addressed byte.

Two static inputs select the policies. `cfg_write_back` chooses between keeping writes in the cache and marking the block dirty, or forwarding every write to memory as it happens. `cfg_write_alloc` chooses whether a write miss first brings the block into the cache.

A state machine drives the controller, with these states:

- IDLE: waits for a request. A request moves it to LOOKUP.
- LOOKUP: compares both tags against the captured address. A completed hit returns to IDLE. A write-through write hit goes to FWD. A miss with a dirty victim goes to EVICT. Any other allocating miss goes to FETCH. A no-allocate write miss goes to FWD.
- EVICT: writes the victim block back to memory, then moves to FETCH when `mem_ready` is high.
- FETCH: reads the new block. It then goes to FWD for a write-through write, and to REPLY otherwise.
- FWD: performs a byte write to memory, then moves to REPLY when `mem_ready` is high.
- REPLY: answers the requester, then returns to IDLE.

Top module: `sa2_cache_ctrl`

## Requirements
- R1: The address is split as follows: bits [7:5] are the tag, bits [4:3] are the set, and bits [2:0] select the byte inside the block. A block is carried on the 64-bit memory buses with byte k in bits [8k+7:8k].
- R2: After synchronous reset `busy`, `resp_valid` and `mem_req` are low. Every block is invalid and clean, so the first access to any address misses.
- R3: A load hit answers in the cycle after the request is accepted, with `resp_hit` high and the addressed byte on `resp_rdata`. It starts no memory transaction.
- R4: Two blocks with the same set and different tags are held together. The sequence A, B, A, B gives miss, miss, hit, hit, and at most one way ever matches.
- R5: A miss fills an invalid way first, trying way 0 before way 1. With both ways valid it replaces the way named by the set's replacement bit. That bit is set to the other way on every hit and on every fill.
- R6: In write-back mode a write hit changes only the cached byte, marks the block dirty and answers in the cycle after acceptance, with no memory transaction.
- R7: A miss whose victim is dirty first issues a block write (`mem_op` = 1) of the victim to address {victim tag, set, 000}. Only after that does it issue a block read (`mem_op` = 0) of the new block.
- R8: In write-through mode every write is sent as a byte write (`mem_op` = 2) carrying the full address and data, and no block becomes dirty. A clean victim is dropped without a block write.
- R9: With allocation on, a write miss reads the block, merges the written byte, and later loads of that block hit.
- R10: With allocation off, a write miss only issues the byte write and leaves the cache unchanged, so a later load of that address misses.
- R11: `busy` is high from the cycle after acceptance through the response cycle. A memory request holds its operation and address until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_write_back | input | 1 | 1: write-back, 0: write-through |
| cfg_write_alloc | input | 1 | 1: allocate on write miss |
| req_valid | input | 1 | Request present, taken when busy is low |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Store data |
| busy | output | 1 | Controller occupied |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Access hit in the cache |
| resp_rdata | output | 8 | Loaded byte (0 for stores) |
| mem_req | output | 1 | Memory transaction requested |
| mem_op | output | 2 | 0 block read, 1 block write, 2 byte write |
| mem_addr | output | 8 | Block base or byte address |
| mem_wblock | output | 64 | Block written back |
| mem_wbyte | output | 8 | Byte forwarded |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rblock | input | 64 | Block returned on a read |

## Verification
The hardest situation to reach is a dirty block falling out as the replacement victim. Reaching it needs two valid ways in one set, a write hit in write-back mode, and then a third tag in that set, arriving while the replacement bit points at the dirty way. The directed sequence builds exactly that order. A long pseudo-random phase then restricts tags to four values per set, so that conflict evictions of dirty and clean blocks happen often under all four policy combinations. A behavioural model predicts every hit flag, every loaded byte and the exact ordered list of memory transactions.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;
    localparam int TAG_W  = 3;
    localparam int IDX_W  = 2;
    localparam int OFF_W  = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MOP_RD_BLK  = 2'd0,
        MOP_WR_BLK  = 2'd1,
        MOP_WR_BYTE = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FETCH,
        ST_FWD,
        ST_REPLY
    } ctl_state_e;
endpackage

// File: rtl/sa2_tag_store.sv
module sa2_tag_store #(
    parameter int TAG_W = 3,
    parameter int IDX_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           idx,
    input  logic [TAG_W-1:0]           lk_tag,
    output logic [1:0]                 hit_vec,
    output logic                       vict_way,
    output logic                       vict_dirty,
    output logic [1:0][TAG_W-1:0]      way_tag,
    input  logic                       touch_en,
    input  logic                       touch_way,
    input  logic                       fill_en,
    input  logic                       fill_way,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic                       fill_dirty,
    input  logic                       mark_en,
    input  logic                       mark_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0][1:0] valid_q;
    logic [SETS-1:0][1:0] dirty_q;
    logic [SETS-1:0]      lru_q;
    logic [TAG_W-1:0]     tag_q [SETS][2];

    // parallel compare of both ways
    for (genvar w = 0; w < 2; w++) begin : g_way
        assign way_tag[w] = tag_q[idx][w];
        assign hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == lk_tag);
    end

    // invalid way first, else the way the replacement bit names
    always_comb begin
        if (!valid_q[idx][0])      vict_way = 1'b0;
        else if (!valid_q[idx][1]) vict_way = 1'b1;
        else                       vict_way = lru_q[idx];
        vict_dirty = valid_q[idx][vict_way] && dirty_q[idx][vict_way];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            lru_q   <= '0;
        end else begin
            if (fill_en) begin
                valid_q[idx][fill_way] <= 1'b1;
                dirty_q[idx][fill_way] <= fill_dirty;
                lru_q[idx]             <= ~fill_way;
            end else if (touch_en) begin
                lru_q[idx] <= ~touch_way;
                if (mark_en) dirty_q[idx][mark_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx][fill_way] <= fill_tag;
    end
endmodule

// File: rtl/sa2_data_store.sv
module sa2_data_store #(
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 3,
    parameter int BYTE_W = 8,
    localparam int SETS     = 1 << IDX_W,
    localparam int BLK_BITS = (1 << OFF_W) * BYTE_W
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        idx,
    input  logic [OFF_W-1:0]        off,
    input  logic                    way,
    output logic [1:0][BYTE_W-1:0]  rd_byte,
    output logic [BLK_BITS-1:0]     rd_blk,
    input  logic                    wr_byte_en,
    input  logic [BYTE_W-1:0]       wr_byte,
    input  logic                    wr_blk_en,
    input  logic [BLK_BITS-1:0]     wr_blk
);
    logic [BLK_BITS-1:0] blk_q [SETS][2];

    for (genvar w = 0; w < 2; w++) begin : g_rd
        assign rd_byte[w] = blk_q[idx][w][int'(off)*BYTE_W +: BYTE_W];
    end
    assign rd_blk = blk_q[idx][way];

    always_ff @(posedge clk) begin
        if (wr_blk_en)
            blk_q[idx][way] <= wr_blk;
        else if (wr_byte_en)
            blk_q[idx][way][int'(off)*BYTE_W +: BYTE_W] <= wr_byte;
    end
endmodule

// File: rtl/sa2_cache_fsm.sv
module sa2_cache_fsm
    import sa2_cache_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 3,
    parameter int BYTE_W = 8,
    localparam int ADDR_W   = TAG_W + IDX_W + OFF_W,
    localparam int BLK_BITS = (1 << OFF_W) * BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wb,
    input  logic                       cfg_alloc,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [BYTE_W-1:0]          req_wdata,
    output logic                       busy,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic [BYTE_W-1:0]          resp_rdata,
    output logic                       mem_req,
    output logic [1:0]                 mem_op,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [BLK_BITS-1:0]        mem_wblock,
    output logic [BYTE_W-1:0]          mem_wbyte,
    input  logic                       mem_ready,
    input  logic [BLK_BITS-1:0]        mem_rblock,
    output logic [IDX_W-1:0]           ts_idx,
    output logic [TAG_W-1:0]           ts_tag,
    input  logic [1:0]                 hit_vec,
    input  logic                       vict_way,
    input  logic                       vict_dirty,
    input  logic [1:0][TAG_W-1:0]      way_tag,
    output logic                       touch_en,
    output logic                       touch_way,
    output logic                       fill_en,
    output logic                       fill_way,
    output logic                       fill_dirty,
    output logic                       mark_en,
    output logic                       mark_way,
    output logic [OFF_W-1:0]           ds_off,
    output logic                       ds_way,
    input  logic [1:0][BYTE_W-1:0]     rd_byte,
    input  logic [BLK_BITS-1:0]        rd_blk,
    output logic                       byte_en,
    output logic [BYTE_W-1:0]          byte_data,
    output logic                       blk_en,
    output logic [BLK_BITS-1:0]        blk_data
);
    ctl_state_e           st_q, st_d;
    logic [ADDR_W-1:0]    addr_q;
    logic                 we_q;
    logic [BYTE_W-1:0]    wd_q;
    logic                 way_q;
    logic                 hit_q;

    logic [TAG_W-1:0]     tag_f;
    logic [IDX_W-1:0]     idx_f;
    logic [OFF_W-1:0]     off_f;
    logic                 lk_hit;
    logic                 lk_way;
    logic [BLK_BITS-1:0]  merged;

    assign tag_f  = addr_q[ADDR_W-1 -: TAG_W];
    assign idx_f  = addr_q[OFF_W +: IDX_W];
    assign off_f  = addr_q[OFF_W-1:0];
    assign lk_hit = |hit_vec;
    assign lk_way = hit_vec[1];

    assign ts_idx    = idx_f;
    assign ts_tag    = tag_f;
    assign ds_off    = off_f;
    assign ds_way    = (st_q == ST_LOOKUP) ? lk_way : way_q;
    assign busy      = (st_q != ST_IDLE);
    assign fill_way  = way_q;
    assign fill_dirty = we_q && cfg_wb;
    assign touch_way = lk_way;
    assign mark_way  = lk_way;
    assign byte_data = wd_q;
    assign blk_data  = merged;

    // fetched block with the pending store merged in
    always_comb begin
        merged = mem_rblock;
        if (we_q) merged[int'(off_f)*BYTE_W +: BYTE_W] = wd_q;
    end

    // state register and captured request
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            we_q   <= 1'b0;
            wd_q   <= '0;
            way_q  <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                we_q   <= req_write;
                wd_q   <= req_wdata;
            end
            if (st_q == ST_LOOKUP) begin
                hit_q <= lk_hit;
                way_q <= lk_hit ? lk_way : vict_way;
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (lk_hit)
                    st_d = (we_q && !cfg_wb) ? ST_FWD : ST_IDLE;
                else if (we_q && !cfg_alloc)
                    st_d = ST_FWD;
                else
                    st_d = vict_dirty ? ST_EVICT : ST_FETCH;
            end
            ST_EVICT:  if (mem_ready) st_d = ST_FETCH;
            ST_FETCH:  if (mem_ready) st_d = (we_q && !cfg_wb) ? ST_FWD : ST_REPLY;
            ST_FWD:    if (mem_ready) st_d = ST_REPLY;
            ST_REPLY:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        resp_rdata = '0;
        mem_req    = 1'b0;
        mem_op     = MOP_RD_BLK;
        mem_addr   = '0;
        mem_wblock = '0;
        mem_wbyte  = '0;
        touch_en   = 1'b0;
        fill_en    = 1'b0;
        mark_en    = 1'b0;
        byte_en    = 1'b0;
        blk_en     = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_LOOKUP: begin
                if (lk_hit) begin
                    touch_en = 1'b1;
                    byte_en  = we_q;
                    mark_en  = we_q && cfg_wb;
                    if (!(we_q && !cfg_wb)) begin
                        resp_valid = 1'b1;
                        resp_hit   = 1'b1;
                        resp_rdata = we_q ? '0 : rd_byte[lk_way];
                    end
                end
            end
            ST_EVICT: begin
                mem_req    = 1'b1;
                mem_op     = MOP_WR_BLK;
                mem_addr   = {way_tag[way_q], idx_f, {OFF_W{1'b0}}};
                mem_wblock = rd_blk;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_op   = MOP_RD_BLK;
                mem_addr = {tag_f, idx_f, {OFF_W{1'b0}}};
                fill_en  = mem_ready;
                blk_en   = mem_ready;
            end
            ST_FWD: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WR_BYTE;
                mem_addr  = addr_q;
                mem_wbyte = wd_q;
            end
            ST_REPLY: begin
                resp_valid = 1'b1;
                resp_hit   = hit_q;
                resp_rdata = we_q ? '0 : rd_byte[way_q];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sa2_cache_ctrl.sv
module sa2_cache_ctrl
    import sa2_cache_pkg::*;
#(
    parameter int TAG_W  = sa2_cache_pkg::TAG_W,
    parameter int IDX_W  = sa2_cache_pkg::IDX_W,
    parameter int OFF_W  = sa2_cache_pkg::OFF_W,
    parameter int BYTE_W = sa2_cache_pkg::BYTE_W,
    localparam int ADDR_W   = TAG_W + IDX_W + OFF_W,
    localparam int BLK_BITS = (1 << OFF_W) * BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_write_back,
    input  logic                   cfg_write_alloc,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [BYTE_W-1:0]      req_wdata,
    output logic                   busy,
    output logic                   resp_valid,
    output logic                   resp_hit,
    output logic [BYTE_W-1:0]      resp_rdata,
    output logic                   mem_req,
    output logic [1:0]             mem_op,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [BLK_BITS-1:0]    mem_wblock,
    output logic [BYTE_W-1:0]      mem_wbyte,
    input  logic                   mem_ready,
    input  logic [BLK_BITS-1:0]    mem_rblock
);
    logic [IDX_W-1:0]          ts_idx;
    logic [TAG_W-1:0]          ts_tag;
    logic [1:0]                hit_vec;
    logic                      vict_way, vict_dirty;
    logic [1:0][TAG_W-1:0]     way_tag;
    logic                      touch_en, touch_way;
    logic                      fill_en, fill_way, fill_dirty;
    logic                      mark_en, mark_way;
    logic [OFF_W-1:0]          ds_off;
    logic                      ds_way;
    logic [1:0][BYTE_W-1:0]    rd_byte;
    logic [BLK_BITS-1:0]       rd_blk;
    logic                      byte_en, blk_en;
    logic [BYTE_W-1:0]         byte_data;
    logic [BLK_BITS-1:0]       blk_data;

    sa2_cache_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) fsm_i (
        .clk(clk), .rst(rst),
        .cfg_wb(cfg_write_back), .cfg_alloc(cfg_write_alloc),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
        .mem_wblock(mem_wblock), .mem_wbyte(mem_wbyte),
        .mem_ready(mem_ready), .mem_rblock(mem_rblock),
        .ts_idx(ts_idx), .ts_tag(ts_tag), .hit_vec(hit_vec),
        .vict_way(vict_way), .vict_dirty(vict_dirty), .way_tag(way_tag),
        .touch_en(touch_en), .touch_way(touch_way),
        .fill_en(fill_en), .fill_way(fill_way), .fill_dirty(fill_dirty),
        .mark_en(mark_en), .mark_way(mark_way),
        .ds_off(ds_off), .ds_way(ds_way),
        .rd_byte(rd_byte), .rd_blk(rd_blk),
        .byte_en(byte_en), .byte_data(byte_data),
        .blk_en(blk_en), .blk_data(blk_data)
    );

    sa2_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) tags_i (
        .clk(clk), .rst(rst), .idx(ts_idx), .lk_tag(ts_tag),
        .hit_vec(hit_vec), .vict_way(vict_way), .vict_dirty(vict_dirty), .way_tag(way_tag),
        .touch_en(touch_en), .touch_way(touch_way),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(ts_tag), .fill_dirty(fill_dirty),
        .mark_en(mark_en), .mark_way(mark_way)
    );

    sa2_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) data_i (
        .clk(clk), .idx(ts_idx), .off(ds_off), .way(ds_way),
        .rd_byte(rd_byte), .rd_blk(rd_blk),
        .wr_byte_en(byte_en), .wr_byte(byte_data),
        .wr_blk_en(blk_en), .wr_blk(blk_data)
    );
endmodule

// File: rtl/sa2_cache_chk.sv
module sa2_cache_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              req_valid,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [1:0]        mem_op,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        hit_vec
);
    // R4
    one_way_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R11
    busy_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R11
    idle_after_resp_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!busy && !resp_valid));

    // R11
    mem_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_op) && $stable(mem_addr)));

    // R3
    hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_valid);
endmodule

bind sa2_cache_ctrl sa2_cache_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_op(mem_op), .mem_addr(mem_addr),
    .hit_vec(hit_vec)
);

// File: tb/sa2_cache_ctrl_tb_top.sv
module sa2_cache_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wb = 1'b1, cfg_al = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0, req_wdata = '0;
    logic        busy, resp_valid, resp_hit;
    logic [7:0]  resp_rdata;
    logic        mem_req;
    logic [1:0]  mem_op;
    logic [7:0]  mem_addr;
    logic [63:0] mem_wblock;
    logic [7:0]  mem_wbyte;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rblock = '0;

    always #10 clk = ~clk;

    sa2_cache_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_write_back(cfg_wb), .cfg_write_alloc(cfg_al),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
        .mem_wblock(mem_wblock), .mem_wbyte(mem_wbyte),
        .mem_ready(mem_ready), .mem_rblock(mem_rblock)
    );

    int n_run = 0, n_fail = 0;

    // next-level memory seen by the responder, and the model's own copy
    logic [7:0] tbm [256];
    logic [7:0] mm  [256];
    // reference cache state
    bit         rv  [4][2];
    bit         rdy [4][2];
    logic [2:0] rt  [4][2];
    bit         rl  [4];
    logic [7:0] rdat [4][2][8];

    logic [1:0]  got_op [$];
    logic [7:0]  got_addr [$];
    logic [63:0] got_data [$];

    task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // memory responder: two counted cycles per transaction
    int mcnt = 0;
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            mcnt = 0;
        end else if (mem_req) begin
            mcnt++;
            if (mcnt == 2) begin
                mem_ready = 1'b1;
                got_op.push_back(mem_op);
                got_addr.push_back(mem_addr);
                if (mem_op == 2'd0) begin
                    for (int i = 0; i < 8; i++) mem_rblock[i*8 +: 8] = tbm[{mem_addr[7:3], 3'(i)}];
                    got_data.push_back(64'd0);
                end else if (mem_op == 2'd1) begin
                    for (int i = 0; i < 8; i++) tbm[{mem_addr[7:3], 3'(i)}] = mem_wblock[i*8 +: 8];
                    got_data.push_back(mem_wblock);
                end else begin
                    tbm[mem_addr] = mem_wbyte;
                    got_data.push_back({56'd0, mem_wbyte});
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            rl[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin rv[s][w] = 1'b0; rdy[s][w] = 1'b0; end
        end
    endtask

    task automatic access(string r, bit we, logic [7:0] a, logic [7:0] d);
        logic [1:0]  eo [$];
        logic [7:0]  ea [$];
        logic [63:0] ed [$];
        logic [63:0] blk;
        logic [2:0] t; logic [1:0] s; logic [2:0] o;
        int hw, v, cyc;
        bit exp_hit, busy_ok, quick;
        logic [7:0] exp_rd;
        t = a[7:5]; s = a[4:3]; o = a[2:0];
        hw = -1;
        for (int w = 0; w < 2; w++) if (rv[s][w] && rt[s][w] == t) hw = w;
        exp_rd = 8'd0;
        quick = 1'b0;
        if (hw >= 0) begin
            exp_hit = 1'b1;
            rl[s] = (hw == 0);
            if (we) begin
                rdat[s][hw][o] = d;
                if (cfg_wb) begin rdy[s][hw] = 1'b1; quick = 1'b1; end
                else begin eo.push_back(2); ea.push_back(a); ed.push_back({56'd0, d}); mm[a] = d; end
            end else begin
                exp_rd = rdat[s][hw][o];
                quick = 1'b1;
            end
        end else begin
            exp_hit = 1'b0;
            if (we && !cfg_al) begin
                eo.push_back(2); ea.push_back(a); ed.push_back({56'd0, d}); mm[a] = d;
            end else begin
                v = !rv[s][0] ? 0 : (!rv[s][1] ? 1 : int'(rl[s]));
                if (rv[s][v] && rdy[s][v]) begin
                    for (int i = 0; i < 8; i++) begin
                        blk[i*8 +: 8] = rdat[s][v][i];
                        mm[{rt[s][v], s, 3'(i)}] = rdat[s][v][i];
                    end
                    eo.push_back(1); ea.push_back({rt[s][v], s, 3'b000}); ed.push_back(blk);
                end
                eo.push_back(0); ea.push_back({t, s, 3'b000}); ed.push_back(64'd0);
                for (int i = 0; i < 8; i++) rdat[s][v][i] = mm[{t, s, 3'(i)}];
                rv[s][v] = 1'b1; rt[s][v] = t; rdy[s][v] = 1'b0; rl[s] = (v == 0);
                if (we) begin
                    rdat[s][v][o] = d;
                    if (cfg_wb) rdy[s][v] = 1'b1;
                    else begin eo.push_back(2); ea.push_back(a); ed.push_back({56'd0, d}); mm[a] = d; end
                end else exp_rd = rdat[s][v][o];
            end
        end

        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; busy_ok = 1'b1;
        while (!resp_valid && cyc < 200) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(r, "response seen", 64'(resp_valid), 64'd1);
        chk("R11", "busy held until response", 64'(busy_ok && busy), 64'd1);
        chk(r, "hit flag", 64'(resp_hit), 64'(exp_hit));
        if (!we) chk(r, "load data", 64'(resp_rdata), 64'(exp_rd));
        if (quick) chk("R3", "single-cycle completion", 64'(cyc), 64'd1);
        chk(r, "memory transaction count", 64'(got_op.size()), 64'(eo.size()));
        for (int i = 0; i < eo.size() && i < got_op.size(); i++) begin
            chk(r, "memory op/addr", {54'd0, got_op[i], got_addr[i]}, {54'd0, eo[i], ea[i]});
            chk(r, "memory data", got_data[i], ed[i]);
        end
        got_op.delete(); got_addr.delete(); got_data.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual 150000 cycles expected completion before");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        for (int i = 0; i < 256; i++) begin
            tbm[i] = 8'(i * 37 + 5);
            mm[i]  = tbm[i];
        end
        do_reset();
        @(negedge clk);
        // R2: reset state
        chk("R2", "busy after reset", 64'(busy), 64'd0);
        chk("R2", "resp_valid after reset", 64'(resp_valid), 64'd0);
        chk("R2", "mem_req after reset", 64'(mem_req), 64'd0);

        // write-back, allocate
        cfg_wb = 1'b1; cfg_al = 1'b1;
        access("R2", 1'b0, 8'h00, 8'h00);      // cold miss
        access("R1", 1'b0, 8'h05, 8'h00);      // offset select, hit
        access("R4", 1'b0, 8'h40, 8'h00);      // B miss same set
        access("R4", 1'b0, 8'h00, 8'h00);      // A hit
        access("R4", 1'b0, 8'h40, 8'h00);      // B hit
        access("R6", 1'b1, 8'h41, 8'h5A);      // write hit, dirty, no traffic
        access("R5", 1'b0, 8'h80, 8'h00);      // evict clean LRU way (A)
        access("R7", 1'b0, 8'hE0, 8'h00);      // evict dirty B: write-back then read
        access("R7", 1'b0, 8'h41, 8'h00);      // B returns with written byte
        access("R9", 1'b1, 8'h9B, 8'hC3);      // allocating write miss
        access("R9", 1'b0, 8'h9B, 8'h00);      // now hits
        cfg_al = 1'b0;
        access("R10", 1'b1, 8'h2C, 8'h11);     // no-allocate write miss, write-back mode
        access("R10", 1'b0, 8'h2C, 8'h00);     // still misses

        // write-through
        do_reset();
        cfg_wb = 1'b0; cfg_al = 1'b1;
        access("R8", 1'b0, 8'h10, 8'h00);
        access("R8", 1'b1, 8'h12, 8'h77);      // forwarded byte write
        access("R8", 1'b0, 8'h12, 8'h00);
        access("R9", 1'b1, 8'h28, 8'h66);      // fetch then forward
        access("R8", 1'b0, 8'h50, 8'h00);
        access("R8", 1'b0, 8'h90, 8'h00);      // clean eviction, no block write
        cfg_al = 1'b0;
        access("R10", 1'b1, 8'h38, 8'h99);
        access("R10", 1'b0, 8'h38, 8'h00);     // miss, sees forwarded byte

        // pseudo-random phases across all policy pairs
        seed = 32'h1234_5678;
        for (int p = 0; p < 4; p++) begin
            do_reset();
            cfg_wb = p[0]; cfg_al = p[1];
            for (int k = 0; k < 150; k++) begin
                seed = seed * 1103515245 + 12345;
                access("R5", seed[20], {1'b0, seed[17:16], seed[13:12], seed[10:8]}, seed[31:24]);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule